// File: doc/BRIEF.md
# Nine-Bit Serial Frame Transmitter

This block sends one asynchronous serial frame on a single output line each time the host writes a byte. A frame holds eleven bit periods. First comes a low start bit. The eight data bits follow, least significant first, then a ninth bit whose value the host holds on a separate input, and finally a high stop bit. The line rests high whenever no frame is on it.

Bit timing comes from a divide-by-16 counter. It runs freely and steps once per oversampling tick. The tick can come from an internal prescaler, which gives a bit rate of 1/32 or 1/64 of the clock, or from an external one-cycle pulse. A write does not start the frame at once. The frame waits for the next wrap of the divide-by-16 counter, so bit edges always fall on counter wraps. The end of the frame is found by a marker pattern in the shift register, which fills with zeros behind the marker. When the frame ends, a sticky completion flag rises and stays set until the host clears it.

Top module: `ninebit_tx`

## Requirements
- R1: After reset, `txd` is 1 and `done` is 0.
- R2: A frame places on `txd`, one bit time each, 0 (start), `wr_data[0]` through `wr_data[7]` in that order, the ninth bit, then 1 (stop). One bit time is 16 oversampling ticks.
- R3: The ninth bit is the value of `bit9_in` in the cycle `wr_en` is accepted. Later changes of `bit9_in` do not alter the frame.
- R4: After an accepted write, `txd` stays 1 until the first counter wrap that falls strictly after the write edge. The start bit begins at that wrap. A wrap on the same edge as the write does not start the frame.
- R5: `done` rises at the 11th counter wrap after the write. This is the same edge at which the stop bit begins, and `txd` is 1 from then on.
- R6: `done` stays 1 until `clr_done` is high at a clock edge, and reads 0 after that edge. If completion and `clr_done` fall on the same edge, `done` ends up 1.
- R7: A write while a frame is pending or in progress is ignored. The current frame goes out unchanged, and no further frame follows it.
- R8: With `use_ext`=0, one bit time lasts 32 clocks when `slow_sel`=0 and 64 clocks when `slow_sel`=1. With `use_ext`=1, each clock cycle with `ext_tick` high is one oversampling tick.
- R9: A write accepted on the cycle right after completion starts a new frame under the rules of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle data write strobe |
| wr_data | input | 8 | Byte to send |
| bit9_in | input | 1 | Held ninth-bit value, sampled on the write |
| clr_done | input | 1 | Clears the completion flag |
| use_ext | input | 1 | 1: take ticks from ext_tick; 0: internal prescaler |
| slow_sel | input | 1 | Internal prescaler: 0 gives clk/32 bits, 1 gives clk/64 bits |
| ext_tick | input | 1 | External oversampling tick, one cycle wide |
| txd | output | 1 | Serial line, idles high |
| done | output | 1 | Sticky frame-complete flag |

## Verification
The bench places writes on the very edge where the counter wraps. A design that counted that wrap would start the start bit 16 ticks too early. It also picks data bytes whose low bits look like the end marker before the stop bit is loaded. A design with an ungated marker test would cut the frame short after only a few data bits. Other cases cover a write injected in mid-frame, which a flawed design would turn into corrupted bits or a stray second frame, and a clear that arrives on the completion edge, which a design with the wrong priority would lose. Both prescaler rates are timed edge to edge so that an off-by-one divider shows up.

// File: rtl/ninebit_tx_pkg.sv
package ninebit_tx_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_PEND  = 2'd1,
    TX_START = 2'd2,
    TX_DATA  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/ninebit_tx_tick.sv
module ninebit_tx_tick #(
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_ext,
  input  logic slow_sel,
  input  logic ext_tick,
  output logic tick
);
  localparam int PW = $clog2(SLOW_DIV);
  localparam int FW = $clog2(FAST_DIV);

  logic [PW-1:0] pc_q, pc_d;
  logic          fast_hit, slow_hit;

  always_comb begin
    pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign fast_hit = (pc_q[FW-1:0] == {FW{1'b1}});
  assign slow_hit = (pc_q == {PW{1'b1}});

  always_comb begin
    if (use_ext)       tick = ext_tick;
    else if (slow_sel) tick = slow_hit;
    else               tick = fast_hit;
  end

  // R8
  prescale_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_ext && tick) |=> (use_ext || !tick));
endmodule

// File: rtl/ninebit_tx_div16.sv
module ninebit_tx_div16 #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic roll
);
  localparam int CW = $clog2(OVS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_top;

  assign at_top = (cnt_q == CW'(OVS-1));
  assign roll   = tick && at_top;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = at_top ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  wrap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> (cnt_q == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
endmodule

// File: rtl/ninebit_tx_ctrl.sv
module ninebit_tx_ctrl
  import ninebit_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              roll,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bit9_in,
  input  logic              clr_done,
  output logic              txd,
  output logic              done
);
  localparam int SR_W = DATA_W + 1;

  tx_state_e       st_q, st_d;
  logic [SR_W-1:0] sr_q, sr_d;
  logic            stop_q, stop_d;
  logic            done_q, done_d;
  logic            txd_q, txd_d;
  logic            marker;
  logic            busy;

  // stop bit sits just above the ninth bit, only zeros above it
  assign marker = (sr_q[SR_W-1:2] == '0) && sr_q[1];
  assign busy   = (st_q != TX_IDLE);

  always_comb begin
    st_d   = st_q;
    sr_d   = sr_q;
    stop_d = stop_q;
    done_d = done_q;
    if (clr_done) done_d = 1'b0;
    unique case (st_q)
      TX_IDLE: begin
        if (wr_en) begin
          sr_d   = {bit9_in, wr_data};
          stop_d = 1'b0;
          st_d   = TX_PEND;
        end
      end
      TX_PEND: begin
        if (roll) st_d = TX_START;
      end
      TX_START: begin
        if (roll) st_d = TX_DATA;
      end
      TX_DATA: begin
        if (roll) begin
          if (stop_q && marker) begin
            sr_d   = {1'b0, sr_q[SR_W-1:1]};
            st_d   = TX_IDLE;
            done_d = 1'b1;
          end else begin
            sr_d   = {~stop_q, sr_q[SR_W-1:1]};
            stop_d = 1'b1;
          end
        end
      end
      default: st_d = TX_IDLE;
    endcase
    unique case (st_d)
      TX_START: txd_d = 1'b0;
      TX_DATA:  txd_d = sr_d[0];
      default:  txd_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      sr_q   <= '0;
      stop_q <= 1'b0;
      done_q <= 1'b0;
      txd_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      sr_q   <= sr_d;
      stop_q <= stop_d;
      done_q <= done_d;
      txd_q  <= txd_d;
    end
  end

  assign txd  = txd_q;
  assign done = done_q;

  // R7
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && !roll) |=> $stable(sr_q));

  // R4
  pend_waits_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_PEND && !roll) |=> (st_q == TX_PEND && txd));

  // R5
  done_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(st_q) == TX_DATA && st_q == TX_IDLE && txd));

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr_done) |=> done_q);
endmodule

// File: rtl/ninebit_tx.sv
module ninebit_tx #(
  parameter int DATA_W   = 8,
  parameter int OVS      = 16,
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bit9_in,
  input  logic              clr_done,
  input  logic              use_ext,
  input  logic              slow_sel,
  input  logic              ext_tick,
  output logic              txd,
  output logic              done
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       tick;
  logic       roll;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ninebit_tx_tick #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_tick (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .use_ext  (use_ext),
    .slow_sel (slow_sel),
    .ext_tick (ext_tick),
    .tick     (tick)
  );

  ninebit_tx_div16 #(.OVS(OVS)) u_div (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (tick),
    .roll  (roll)
  );

  ninebit_tx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .roll     (roll),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .bit9_in  (bit9_in),
    .clr_done (clr_done),
    .txd      (txd),
    .done     (done)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    (!rst_int_n) |=> (txd && !done));
endmodule

// File: tb/tb_ninebit_tx.sv
module tb_ninebit_tx;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, bit9_in, clr_done, use_ext, slow_sel, ext_tick;
  logic [7:0] wr_data;
  logic       txd, done;

  int total = 0;
  int fails = 0;
  int tcnt  = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  ninebit_tx dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .bit9_in(bit9_in), .clr_done(clr_done), .use_ext(use_ext),
    .slow_sel(slow_sel), .ext_tick(ext_tick), .txd(txd), .done(done)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; fails++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 150000);
      summary();
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic frame_bit(logic [7:0] d, logic nb, int j);
    if (j == 0)  return 1'b0;
    if (j <= 8)  return d[j-1];
    if (j == 9)  return nb;
    return 1'b1;
  endfunction

  task automatic do_reset(logic ext, logic slow);
    rst_n = 1'b0; wr_en = 0; wr_data = 0; bit9_in = 0; clr_done = 0;
    use_ext = ext; slow_sel = slow; ext_tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    tcnt = 0;
  endtask

  task automatic pulse(logic clr = 1'b0);
    ext_tick = 1'b1; clr_done = clr;
    @(negedge clk);
    ext_tick = 1'b0; clr_done = 1'b0;
    tcnt++;
    repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  task automatic run_frame(logic [7:0] d, logic nb, logic coincide, logic inject,
                           logic clr_same, int pre);
    if (done) begin
      clr_done = 1'b1; @(negedge clk); clr_done = 1'b0;
      check("R6 clear", done, 0);
    end
    if (coincide) begin
      while (tcnt % 16 != 15) pulse();
      wr_en = 1; wr_data = d; bit9_in = nb; ext_tick = 1;
      @(negedge clk);
      wr_en = 0; ext_tick = 0; tcnt++; bit9_in = ~nb;
    end else begin
      repeat (pre) if (tcnt % 16 != 15) pulse();
      wr_en = 1; wr_data = d; bit9_in = nb;
      @(negedge clk);
      wr_en = 0; bit9_in = ~nb;
    end
    check("R4 high after write", txd, 1);
    while (tcnt % 16 != 15) pulse();
    check("R4 high before wrap", txd, 1);
    for (int j = 0; j <= 10; j++) begin
      pulse((j == 10) && clr_same);
      if (j == 9) check("R5 done low before end", done, 0);
      check(j == 9 ? "R3 ninth bit" : "R2 bit at wrap", txd, frame_bit(d, nb, j));
      if (j == 10) begin
        check("R5 done at 11th wrap", done, 1);
      end else begin
        for (int k = 0; k < 15; k++) begin
          if (inject && j == 3 && k == 5) begin
            wr_en = 1; wr_data = ~d; bit9_in = ~nb;
            @(negedge clk);
            wr_en = 0;
          end
          pulse();
          if (k == 7) check("R2 mid bit", txd, frame_bit(d, nb, j));
        end
      end
    end
    if (inject) begin
      for (int r = 0; r < 2; r++) begin
        repeat (16) pulse();
        check("R7 no second frame", txd, 1);
      end
      check("R6 done held", done, 1);
    end
  endtask

  task automatic fixed_rate(logic slow);
    int n;
    logic prev;
    do_reset(1'b0, slow);
    check("R1 txd reset", txd, 1);
    wr_en = 1; wr_data = 8'h55; bit9_in = 1;
    @(negedge clk); wr_en = 0;
    n = 0;
    while (txd && n < 400) begin @(negedge clk); n++; end
    check("R8 start seen", txd, 0);
    for (int e = 0; e < 3; e++) begin
      prev = txd; n = 0;
      while (txd == prev && n < 200) begin @(negedge clk); n++; end
      check("R8 bit time", n, slow ? 64 : 32);
    end
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    check("R5 done fixed", done, 1);
    check("R5 line high", txd, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset(1'b1, 1'b0);
    check("R1 txd reset", txd, 1);
    check("R1 done reset", done, 0);
    // R4 write on a wrap edge
    run_frame(8'hA6, 1'b1, 1'b1, 1'b0, 1'b0, 0);
    // R9 write right after completion
    run_frame(8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    // marker-lookalike bytes before stop bit is loaded
    run_frame(8'h02, 1'b0, 1'b0, 1'b0, 1'b0, 3);
    run_frame(8'h03, 1'b0, 1'b1, 1'b0, 1'b0, 0);
    // R7 mid-frame write
    run_frame(8'hF0, 1'b1, 1'b0, 1'b1, 1'b0, 5);
    // R6 clear on completion edge
    run_frame(8'h81, 1'b1, 1'b0, 1'b0, 1'b1, 2);
    clr_done = 1; @(negedge clk); clr_done = 0;
    check("R6 clear after set", done, 0);
    repeat (3) @(negedge clk);
    check("R6 stays clear", done, 0);
    for (int i = 0; i < 20; i++) begin
      run_frame(8'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0),
                1'($urandom_range(0, 4) == 0), 1'b0, $urandom_range(0, 20));
    end
    fixed_rate(1'b0);
    fixed_rate(1'b1);
    summary();
  end
endmodule